// File: doc/BRIEF.md
# Downward-Growing Word Stack with Full and Empty Status

This block keeps a last-in-first-out stack of data words in a small register-file memory. A pointer marks the top of the stack and moves toward address 0 as words are added. The bottom of the stack sits at the highest address, DEPTH-1. With the default depth of 11, storage covers addresses 0 through 10 and the empty pointer value is 11.

A push lowers the pointer by one and then stores the input word at the new pointer. A pop copies the word under the pointer into an output data register and then raises the pointer by one. Two status flags report the stack state: one for a full stack and one for an empty stack. The block also shows the current top-of-stack word at all times.

A command that cannot be carried out changes nothing and raises a one-cycle error pulse. This covers a push on a full stack, a pop on an empty stack, and a push and pop in the same cycle. Each accepted command completes in one clock cycle, so commands may follow each other on consecutive cycles.

Top module: `lifo_stack`

## Requirements
- R1: While reset is low and after it is released, the pointer is DEPTH (11), the empty flag is 1, the full flag is 0, the error output is 0 and the pop data register is 0.
- R2: A push accepted at a clock edge lowers the pointer by one and stores the input word at the new pointer. From that edge on, the top-of-stack output shows the pushed word.
- R3: After an accepted push the empty flag is 0. The full flag is 1 exactly when the new pointer is 0.
- R4: A pop accepted at a clock edge loads the pop data register with the word that was on top and raises the pointer by one.
- R5: After an accepted pop the full flag is 0. The empty flag is 1 exactly when the new pointer equals DEPTH.
- R6: A push while the stack is full changes neither the pointer, the flags nor the top-of-stack word. The error output is 1 for the following cycle.
- R7: A pop while the stack is empty changes neither the pointer, the flags nor the pop data register. The error output is 1 for the following cycle.
- R8: Push and pop asserted together are both ignored, and the error output is 1 for the following cycle. The error output is 0 after any cycle with a legal command or no command.
- R9: Words come back from pops in the reverse of the order in which they were pushed, across the full depth of the stack.
- R10: The top-of-stack output reads 0 whenever the stack is empty.
- R11: Legal commands on consecutive clock cycles are each accepted, with no idle cycle between them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| push_i | input | 1 | Push command |
| pop_i | input | 1 | Pop command |
| wdata_i | input | WIDTH | Word to push |
| rdata_o | output | WIDTH | Data register loaded by a pop |
| top_o | output | WIDTH | Current top-of-stack word, 0 when empty |
| ptr_o | output | $clog2(DEPTH+1) | Stack pointer |
| full_o | output | 1 | Stack holds DEPTH words |
| empty_o | output | 1 | Stack holds no words |
| err_o | output | 1 | One-cycle pulse after a refused command |

## Verification
The bench fills the stack to exactly eleven words, so a full flag raised one word early or late shows up as a refused or accepted push at the wrong count. It then pushes once more while full. A design that lets this through would wrap the pointer and overwrite the bottom word, which later pops would reveal.

The bench pops on an empty stack and issues a simultaneous push and pop. A design that handles either case wrongly would move the pointer or change the data register, or fail to pulse the error output. The bench also drains the stack in full and runs pushes and pops back to back. Wrong pre-decrement or post-increment ordering would return neighbouring words, which the scoreboard catches.

// File: rtl/lifo_stack.sv
module lifo_stack #(
  parameter int WIDTH = 16,
  parameter int DEPTH = 11
) (
  input  logic                         clk,
  input  logic                         rst_n,
  input  logic                         push_i,
  input  logic                         pop_i,
  input  logic [WIDTH-1:0]             wdata_i,
  output logic [WIDTH-1:0]             rdata_o,
  output logic [WIDTH-1:0]             top_o,
  output logic [$clog2(DEPTH+1)-1:0]   ptr_o,
  output logic                         full_o,
  output logic                         empty_o,
  output logic                         err_o
);
  localparam int PW = $clog2(DEPTH+1);
  localparam logic [PW-1:0] BOTTOM = PW'(DEPTH);

  logic [WIDTH-1:0] mem [DEPTH];
  logic [PW-1:0]    sp, sp_dn, sp_up, rd_idx;
  logic             full, empty, err;
  logic [WIDTH-1:0] dr;
  logic             do_push, do_pop, bad;

  assign do_push = push_i & ~pop_i & ~full;
  assign do_pop  = pop_i & ~push_i & ~empty;
  assign bad     = (push_i & pop_i) | (push_i & full) | (pop_i & empty);
  assign sp_dn   = sp - 1'b1;
  assign sp_up   = sp + 1'b1;
  assign rd_idx  = empty ? '0 : sp;

  always_ff @(posedge clk) begin
    if (do_push) mem[sp_dn] <= wdata_i;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sp    <= BOTTOM;
      full  <= 1'b0;
      empty <= 1'b1;
      err   <= 1'b0;
      dr    <= '0;
    end else begin
      err <= bad;
      if (do_push) begin
        sp    <= sp_dn;
        full  <= (sp_dn == '0);
        empty <= 1'b0;
      end else if (do_pop) begin
        dr    <= mem[rd_idx];
        sp    <= sp_up;
        empty <= (sp_up == BOTTOM);
        full  <= 1'b0;
      end
    end
  end

  assign top_o   = empty ? '0 : mem[rd_idx];
  assign rdata_o = dr;
  assign ptr_o   = sp;
  assign full_o  = full;
  assign empty_o = empty;
  assign err_o   = err;

  // R2
  push_lands_on_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_push |=> (top_o == $past(wdata_i)) && (ptr_o == $past(ptr_o) - 1'b1));
  // R3
  full_only_at_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    full_o |-> (ptr_o == '0));
  // R4
  pop_takes_top_chk: assert property (@(posedge clk) disable iff (!rst_n)
    do_pop |=> (rdata_o == $past(top_o)) && (ptr_o == $past(ptr_o) + 1'b1));
  // R5
  empty_at_bottom_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o == (ptr_o == BOTTOM));
  // R6
  refused_holds_state_chk: assert property (@(posedge clk) disable iff (!rst_n)
    bad |=> err_o && $stable(ptr_o) && $stable(rdata_o) && $stable(full_o) && $stable(empty_o));
  // R8
  err_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !bad |=> !err_o);
  // R10
  empty_top_zero_chk: assert property (@(posedge clk) disable iff (!rst_n)
    empty_o |-> (top_o == '0));
  // R3
  ptr_in_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ptr_o <= BOTTOM);
endmodule

// File: tb/lifo_stack_tb.sv
`timescale 1ns/1ps
module lifo_stack_tb_top;
  localparam int W = 16;
  localparam int D = 11;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic push = 1'b0, pop = 1'b0;
  logic [W-1:0] wdata = '0;
  logic [W-1:0] rdata, top;
  logic [$clog2(D+1)-1:0] ptr;
  logic full, empty, err;

  int checks = 0;
  int fails = 0;
  bit done = 0;

  logic [W-1:0] model[$];
  logic [W-1:0] exp_q[$];
  logic [W-1:0] exp_dr = '0;
  event pop_ev;

  always #2 clk = ~clk;

  lifo_stack #(.WIDTH(W), .DEPTH(D)) dut_i (
    .clk(clk), .rst_n(rst_n), .push_i(push), .pop_i(pop), .wdata_i(wdata),
    .rdata_o(rdata), .top_o(top), .ptr_o(ptr), .full_o(full),
    .empty_o(empty), .err_o(err));

  task automatic chk(string tag, string what, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  task automatic check_state(string tag, bit exp_err);
    int sz = model.size();
    chk(tag, "ptr", ptr, D - sz);
    chk(tag, "full", full, sz == D);
    chk(tag, "empty", empty, sz == 0);
    chk(tag, "err", err, exp_err);
    chk(tag, "top", top, sz == 0 ? 0 : model[sz-1]);
    chk(tag, "rdata", rdata, exp_dr);
  endtask

  // monitor: compares each popped word with the scoreboard entry (R9, R4)
  initial begin
    forever begin
      @(pop_ev);
      if (exp_q.size() != 0) chk("R9", "popped word", rdata, exp_q.pop_front());
    end
  end

  task automatic op(bit p, bit q, logic [W-1:0] d, string tag);
    bit illegal;
    illegal = (p && q) || (p && model.size() == D) || (q && model.size() == 0);
    push = p; pop = q; wdata = d;
    @(posedge clk);
    @(negedge clk);
    push = 0; pop = 0;
    if (!illegal && p) model.push_back(d);
    if (!illegal && q) begin
      exp_dr = model.pop_back();
      exp_q.push_back(exp_dr);
      -> pop_ev;
    end
    check_state(tag, illegal);
  endtask

  initial begin
    #(4 * 5000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check_state("R1", 0);
    rst_n = 1'b1;
    @(negedge clk);
    check_state("R1", 0);
    chk("R10", "top when empty", top, 0);

    op(0, 1, 16'h0, "R7");
    op(0, 0, 16'h0, "R8");
    for (int i = 0; i < D; i++) op(1, 0, 16'hA100 + 16'(i * 7), i == D-1 ? "R3" : "R2");
    op(1, 0, 16'hDEAD, "R6");
    op(0, 0, 16'h0, "R6");
    op(1, 1, 16'hBEEF, "R8");
    for (int i = 0; i < D; i++) op(0, 1, 16'h0, i == D-1 ? "R5" : "R4");
    chk("R10", "top when drained", top, 0);
    op(0, 1, 16'h0, "R7");
    op(1, 1, 16'h1234, "R8");

    op(1, 0, 16'h0011, "R11");
    op(1, 0, 16'h0022, "R11");
    op(0, 1, 16'h0, "R11");
    op(1, 0, 16'h0033, "R11");
    op(0, 1, 16'h0, "R11");
    op(0, 1, 16'h0, "R11");
    op(1, 0, 16'hFFFF, "R2");
    op(1, 0, 16'h0000, "R2");
    op(0, 1, 16'h0, "R4");
    op(0, 1, 16'h0, "R5");

    repeat (2) @(negedge clk);
    done = 1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule